// File: doc/BRIEF.md
# Wraparound Subroutine Return Stack

This block holds return addresses for a microprogram sequencer. It is a last-in first-out store of eight 12-bit words. A 2-bit command on each clock edge tells the stack to hold, push the data input, pop, or empty itself. The top entry is always visible on the output without waiting for a clock edge, so the sequencer can select a return address in the same cycle it issues a pop.

The stack does not protect itself against overflow. An active-low full flag goes low while all eight words are in use. A ninth push does not stall. The write slot wraps round and the new word replaces the oldest one, so the newest eight stay in order and the flag stays low. A pop on an empty stack is not guarded: its data is meaningless and it leaves the pointer in an unspecified place. Callers are expected to avoid it.

Top module: `ret_stack`

## Requirements
- R1: While reset is low and after it is released, with no command yet applied, `tos` is 0 and `full_n` is 1.
- R2: A push (`cmd` = 2'b01) stores `din`, and after the clock edge `tos` equals that value.
- R3: A pop (`cmd` = 2'b10) on a non-empty stack removes the top entry, and after the edge `tos` shows the entry pushed before it. Up to eight entries come back in exactly reverse push order.
- R4: A hold (`cmd` = 2'b00) leaves both `tos` and `full_n` unchanged.
- R5: `full_n` is 0 exactly when eight entries are stored and 1 otherwise.
- R6: A push while full overwrites the oldest entry and keeps `full_n` at 0. Later pops return the newest eight pushes in reverse order.
- R7: A clear (`cmd` = 2'b11) empties the stack and sets `full_n` to 1. A push that follows is the only entry.
- R8: A pop while full sets `full_n` to 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 hold, 01 push, 10 pop, 11 clear |
| din | input | 12 | Word stored by a push |
| tos | output | 12 | Current top entry, combinational |
| full_n | output | 1 | Low while eight entries are stored |

## Verification
On every cycle the assertions check the following:
- A push's data is on the top output at the next edge.
- A hold freezes both outputs.
- Clear and a pop from full release the flag.
- Pushing while full keeps the flag low.
- The flag always agrees with an occupancy count kept in the checker.

Other behaviour needs whole sequences, so only the bench scenarios can show it:
- Eight words come back in reverse push order.
- A ninth and tenth push evict the oldest words.
- After a clear, a single push is all the stack holds.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tos,
  output logic             full_n
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] OP_HOLD = 2'b00;
  localparam logic [1:0] OP_PUSH = 2'b01;
  localparam logic [1:0] OP_POP  = 2'b10;
  localparam logic [1:0] OP_CLR  = 2'b11;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp;
  logic [PW-1:0]    top_idx;
  logic [PW-1:0]    wp_inc;
  logic [CW-1:0]    cnt;

  assign top_idx = (wp == '0) ? LAST : wp - PW'(1);
  assign wp_inc  = (wp == LAST) ? '0 : wp + PW'(1);
  assign tos     = mem[top_idx];
  assign full_n  = (cnt != CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else begin
      unique case (cmd)
        OP_HOLD: ;
        OP_PUSH: begin
          wp <= wp_inc;
          if (cnt != CMAX) cnt <= cnt + CW'(1);
        end
        OP_POP: begin
          wp <= top_idx;
          if (cnt != '0) cnt <= cnt - CW'(1);
        end
        OP_CLR: begin
          wp  <= '0;
          cnt <= '0;
        end
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (cmd == OP_PUSH && wp == PW'(i))
        mem[i] <= din;
    end
  end
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] tos,
  input logic             full_n
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else if (cmd == 2'b11) occ <= '0;
    else if (cmd == 2'b01 && occ != CW'(DEPTH)) occ <= occ + CW'(1);
    else if (cmd == 2'b10 && occ != '0) occ <= occ - CW'(1);
  end

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 2'b01 |=> tos == $past(din));
  p_hold_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 2'b00 |=> $stable(tos) && $stable(full_n));
  p_full_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (occ != CW'(DEPTH)));
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01 && !full_n) |=> !full_n);
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 2'b11 |=> full_n);
  p_pop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10 && !full_n) |=> full_n);
endmodule

bind ret_stack ret_stack_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din), .tos(tos), .full_n(full_n)
);

// File: tb/ret_stack_test.sv
`timescale 1ns/1ps
module ret_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [11:0] din = '0;
  logic [11:0] tos;
  logic        full_n;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] model[$];
  logic [11:0] q_tos[$];
  bit          q_chk[$];
  logic        q_full[$];
  string       q_req[$];

  ret_stack uut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din), .tos(tos), .full_n(full_n));

  always #2.5 clk = ~clk;

  task automatic op(input logic [1:0] c, input logic [11:0] d, input string req);
    @(negedge clk);
    cmd = c;
    din = d;
    case (c)
      2'b01: begin
        if (model.size() == 8) void'(model.pop_front());
        model.push_back(d);
      end
      2'b10: if (model.size() > 0) void'(model.pop_back());
      2'b11: model.delete();
      default: ;
    endcase
    q_chk.push_back(model.size() > 0);
    q_tos.push_back(model.size() > 0 ? model[$] : 12'h000);
    q_full.push_back(model.size() != 8);
    q_req.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_req.size() > 0) begin
      logic [11:0] et;
      bit          ec;
      logic        ef;
      string       r;
      et = q_tos.pop_front();
      ec = q_chk.pop_front();
      ef = q_full.pop_front();
      r  = q_req.pop_front();
      vectors++;
      if (full_n !== ef || (ec && tos !== et)) begin
        errors++;
        $display("FAIL %s: tos=%h full_n=%b expected tos=%h full_n=%b",
                 r, tos, full_n, et, ef);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (tos !== 12'h000 || full_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: tos=%h full_n=%b expected tos=000 full_n=1", tos, full_n);
    end
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (tos !== 12'h000 || full_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: tos=%h full_n=%b expected tos=000 full_n=1", tos, full_n);
    end

    op(2'b01, 12'h111, "R2");
    op(2'b01, 12'h222, "R2");
    op(2'b01, 12'h333, "R2");
    op(2'b00, 12'hFFF, "R4");
    op(2'b00, 12'h0F0, "R4");
    op(2'b10, 12'h000, "R3");
    op(2'b01, 12'hA5A, "R2");
    op(2'b10, 12'h000, "R3");
    op(2'b10, 12'h000, "R3");
    op(2'b11, 12'h000, "R7");

    for (int i = 0; i < 8; i++) op(2'b01, 12'h100 + 12'(i), "R5");
    op(2'b00, 12'h000, "R4");
    op(2'b01, 12'hF00, "R6");
    op(2'b01, 12'hF01, "R6");
    op(2'b10, 12'h000, "R8");
    for (int i = 0; i < 6; i++) op(2'b10, 12'h000, "R6");

    op(2'b11, 12'h000, "R7");
    for (int i = 0; i < 8; i++) op(2'b01, 12'h200 + 12'(i * 3), "R5");
    for (int i = 0; i < 7; i++) op(2'b10, 12'h000, "R3");
    for (int i = 0; i < 7; i++) op(2'b01, 12'h300 + 12'(i), "R5");
    op(2'b11, 12'h000, "R7");
    op(2'b01, 12'h0C3, "R7");
    op(2'b00, 12'h000, "R4");
    op(2'b00, 12'h000, "R4");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule